// File: doc/BRIEF.md
# Interrupt Status Register Aggregator

This block is the 32-bit interrupt status register of a bus bridge. It collects single-cycle event pulses from the bridge into sticky status flags. Software reads the flags at one register address and clears them by writing ones. Each event arrives with its own mask input, and a masked event leaves its flag untouched. Five of the flags record the same error events that a companion status register elsewhere also records. The two copies are set together but cleared separately, so clearing a flag here touches no other state. Two further bits are not stored here at all. They are live copies of a BIST start bit and a PME status bit held in other blocks, and they can only be cleared where they are held.

The flags are grouped onto four interrupt lines. Error-class flags drive a main level interrupt. The configuration-write flag drives its own line. The four message-related bits share one inbound-message line. The BIST copy drives a BIST line through an enable input.

Top module: `isr_aggregator`

## Requirements
- R1: After reset every stored flag is zero, and a read of the register address returns 0 while both copy inputs are low.
- R2: An unmasked pulse on err_evt_i[k] sets bit k (k = 0..4). ibus_err_evt_i sets bit 5, cfg_wr_evt_i sets bit 18, vmsg_evt_i sets bit 25, hp_evt_i sets bit 26 and slot_evt_i sets bit 28. Each flag becomes visible in the cycle after the event edge and stays set until it is cleared.
- R3: A write strobe at the register address clears every stored flag whose write-data bit is 1 and leaves flags with a 0 unchanged. A write to any other address changes nothing.
- R4: An event whose mask input is high in the same cycle does not set its flag.
- R5: If an unmasked event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R6: Bit 24 reads as bist_start_i. irq_bist_o equals bist_start_i AND bist_ie_i.
- R7: Bit 27 reads as pme_stat_i, and writing 1 to bit 27 has no effect on it.
- R8: irq_msg_o is high exactly when bit 25, 26 or 28 is set, or when pme_stat_i and pme_ie_i are both high.
- R9: irq_cfg_o is high exactly when bit 18 is set.
- R10: irq_main_o is high while any of bits 0 to 5 or bit 18 is set, and it falls once all of them are cleared.
- R11: Bits 31:29 and 23:19 always read as zero, including after a write of all ones.
- R12: reg_rdata_o shows the full register value in the same cycle whenever reg_addr_i equals the register address, and shows 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | 5 | Error event pulses shared with the companion register (bits 4:0) |
| err_mask_i | input | 5 | Masks for err_evt_i |
| ibus_err_evt_i | input | 1 | Internal bus error pulse (bit 5) |
| ibus_err_mask_i | input | 1 | Mask for ibus_err_evt_i |
| cfg_wr_evt_i | input | 1 | Configuration write to an enabled function (bit 18) |
| cfg_wr_mask_i | input | 1 | Mask for cfg_wr_evt_i |
| vmsg_evt_i | input | 1 | Inbound vendor message received (bit 25) |
| vmsg_mask_i | input | 1 | Mask for vmsg_evt_i |
| hp_evt_i | input | 1 | Hot-plug indicator change message (bit 26) |
| hp_mask_i | input | 1 | Mask for hp_evt_i |
| slot_evt_i | input | 1 | Slot power limit message (bit 28) |
| slot_mask_i | input | 1 | Mask for slot_evt_i |
| bist_start_i | input | 1 | External BIST start bit, copied to bit 24 |
| bist_ie_i | input | 1 | BIST interrupt enable |
| pme_stat_i | input | 1 | External PME status bit, copied to bit 27 |
| pme_ie_i | input | 1 | PME interrupt enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Single-cycle write strobe |
| reg_wdata_i | input | 32 | Write data, 1 clears the matching flag |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_main_o | output | 1 | Error-class interrupt |
| irq_cfg_o | output | 1 | Configuration-write interrupt |
| irq_msg_o | output | 1 | Inbound-message interrupt |
| irq_bist_o | output | 1 | BIST interrupt |

## Verification
First, each event is pulsed on its own. This shows whether every source lands on its own bit and on the correct interrupt line. Next, the events are repeated with their masks high, and clears are written with mixed one/zero patterns and at a wrong address. These runs separate gating faults from clear-decode faults. Clears that land in the same cycle as events test the set-over-clear priority. Toggling the copy inputs and their enables, and writing all ones, shows whether bits 24, 27 and the reserved bits are really uncleared and constant. A long random mix is then checked every cycle against a behavioural model.

// File: rtl/isr_agg_pkg.sv
package isr_agg_pkg;
    localparam int REG_W    = 32;
    localparam int N_ERR    = 5;
    localparam int N_STICKY = N_ERR + 5;

    localparam int POS_IBUS = 5;
    localparam int POS_CFG  = 18;
    localparam int POS_BIST = 24;
    localparam int POS_VMSG = 25;
    localparam int POS_HP   = 26;
    localparam int POS_PME  = 27;
    localparam int POS_SLOT = 28;

    localparam int IDX_IBUS = N_ERR;
    localparam int IDX_CFG  = N_ERR + 1;
    localparam int IDX_VMSG = N_ERR + 2;
    localparam int IDX_HP   = N_ERR + 3;
    localparam int IDX_SLOT = N_ERR + 4;

    localparam logic [REG_W-1:0] RSVD_BITS = 32'hE0F8_0000;

    // bank index -> register bit position
    function automatic int sticky_pos(input int idx);
        if (idx < N_ERR) return idx;
        case (idx)
            IDX_IBUS: return POS_IBUS;
            IDX_CFG:  return POS_CFG;
            IDX_VMSG: return POS_VMSG;
            IDX_HP:   return POS_HP;
            default:  return POS_SLOT;
        endcase
    endfunction
endpackage

// File: rtl/isr_sticky_bank.sv
module isr_sticky_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;
    logic [N-1:0] set_eff;

    always_comb begin
        st_d    = st_q;
        set_eff = set_i & ~mask_i;
        for (int i = 0; i < N; i++) begin
            if (set_eff[i])     st_d.flag[i] = 1'b1;
            else if (clr_i[i])  st_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2/R5: an unmasked event sets the flag even against a clear
        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[g] && !mask_i[g]) |=> flag_o[g]);
        // R3: a clear without a live event drops the flag
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !(set_i[g] && !mask_i[g])) |=> !flag_o[g]);
        // R4: without an unmasked event a flag never rises
        p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(set_i[g] && !mask_i[g]) |=> !$rose(flag_o[g]));
        // R2: a flag holds with neither event nor clear
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!(set_i[g] && !mask_i[g]) && !clr_i[g]) |=> $stable(flag_o[g]));
    end
endmodule

// File: rtl/isr_readback.sv
module isr_readback
    import isr_agg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ISR_ADDR = 8'h78,
    parameter int                N        = N_STICKY
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [N-1:0]      flag_i,
    input  logic              bist_i,
    input  logic              pme_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [N-1:0]      clr_o
);
    logic             hit;
    logic [REG_W-1:0] image;

    assign hit = (addr_i == ISR_ADDR);

    for (genvar g = 0; g < N; g++) begin : g_clr
        localparam int P = sticky_pos(g);
        assign clr_o[g] = wr_i && hit && wdata_i[P];
    end

    always_comb begin
        image = '0;
        for (int i = 0; i < N; i++) image[sticky_pos(i)] = flag_i[i];
        image[POS_BIST] = bist_i;
        image[POS_PME]  = pme_i;
        rdata_o = hit ? image : '0;
    end

    // R11: reserved bits never show on the read port
    always_comb begin
        a_rsvd_r11: assert ((rdata_o & RSVD_BITS) == '0);
    end
endmodule

// File: rtl/isr_irq_combine.sv
module isr_irq_combine
    import isr_agg_pkg::*;
#(
    parameter int N = N_STICKY
) (
    input  logic [N-1:0] flag_i,
    input  logic         bist_i,
    input  logic         bist_ie_i,
    input  logic         pme_i,
    input  logic         pme_ie_i,
    output logic         irq_main_o,
    output logic         irq_cfg_o,
    output logic         irq_msg_o,
    output logic         irq_bist_o
);
    always_comb begin
        irq_main_o = (|flag_i[N_ERR-1:0]) | flag_i[IDX_IBUS] | flag_i[IDX_CFG];
        irq_cfg_o  = flag_i[IDX_CFG];
        irq_msg_o  = flag_i[IDX_VMSG] | flag_i[IDX_HP] | flag_i[IDX_SLOT]
                   | (pme_i & pme_ie_i);
        irq_bist_o = bist_i & bist_ie_i;
    end
endmodule

// File: rtl/isr_aggregator.sv
module isr_aggregator
    import isr_agg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ISR_ADDR = 8'h78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ERR-1:0]  err_evt_i,
    input  logic [N_ERR-1:0]  err_mask_i,
    input  logic              ibus_err_evt_i,
    input  logic              ibus_err_mask_i,
    input  logic              cfg_wr_evt_i,
    input  logic              cfg_wr_mask_i,
    input  logic              vmsg_evt_i,
    input  logic              vmsg_mask_i,
    input  logic              hp_evt_i,
    input  logic              hp_mask_i,
    input  logic              slot_evt_i,
    input  logic              slot_mask_i,
    input  logic              bist_start_i,
    input  logic              bist_ie_i,
    input  logic              pme_stat_i,
    input  logic              pme_ie_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_main_o,
    output logic              irq_cfg_o,
    output logic              irq_msg_o,
    output logic              irq_bist_o
);
    logic [N_STICKY-1:0] set_vec, mask_vec, clr_vec, flag_vec;

    assign set_vec  = {slot_evt_i, hp_evt_i, vmsg_evt_i, cfg_wr_evt_i,
                       ibus_err_evt_i, err_evt_i};
    assign mask_vec = {slot_mask_i, hp_mask_i, vmsg_mask_i, cfg_wr_mask_i,
                       ibus_err_mask_i, err_mask_i};

    isr_sticky_bank #(.N(N_STICKY)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .mask_i (mask_vec),
        .clr_i  (clr_vec),
        .flag_o (flag_vec)
    );

    isr_readback #(.ADDR_W(ADDR_W), .ISR_ADDR(ISR_ADDR), .N(N_STICKY)) u_rd (
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .flag_i  (flag_vec),
        .bist_i  (bist_start_i),
        .pme_i   (pme_stat_i),
        .rdata_o (reg_rdata_o),
        .clr_o   (clr_vec)
    );

    isr_irq_combine #(.N(N_STICKY)) u_irq (
        .flag_i     (flag_vec),
        .bist_i     (bist_start_i),
        .bist_ie_i  (bist_ie_i),
        .pme_i      (pme_stat_i),
        .pme_ie_i   (pme_ie_i),
        .irq_main_o (irq_main_o),
        .irq_cfg_o  (irq_cfg_o),
        .irq_msg_o  (irq_msg_o),
        .irq_bist_o (irq_bist_o)
    );

    // R9: configuration interrupt rises only after an unmasked config write
    p_cfg_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cfg_o) |-> $past(cfg_wr_evt_i && !cfg_wr_mask_i));
    // R10: main interrupt drops only under a write strobe at the register
    p_main_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_main_o) |-> $past(reg_wr_i && reg_addr_i == ISR_ADDR));
    // R7: bit 27 tracks the external PME status on a read hit
    p_pme_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ISR_ADDR) |-> (reg_rdata_o[POS_PME] == pme_stat_i));
    // R12: a miss reads zero
    p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i != ISR_ADDR) |-> (reg_rdata_o == '0));
endmodule

// File: tb/isr_aggregator_test.sv
`timescale 1ns/1ps
module isr_aggregator_test;
    localparam logic [7:0] A = 8'h78;
    localparam logic [31:0] STICKY = 32'h1604_003F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] ev = '0, mk = '0;
    logic bist = 0, bist_ie = 0, pme = 0, pme_ie = 0;
    logic [7:0] addr = A;
    logic wr = 0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic irq_main, irq_cfg, irq_msg, irq_bist;

    isr_aggregator uut (
        .clk(clk), .rst_n(rst_n),
        .err_evt_i(ev[4:0]), .err_mask_i(mk[4:0]),
        .ibus_err_evt_i(ev[5]), .ibus_err_mask_i(mk[5]),
        .cfg_wr_evt_i(ev[18]), .cfg_wr_mask_i(mk[18]),
        .vmsg_evt_i(ev[25]), .vmsg_mask_i(mk[25]),
        .hp_evt_i(ev[26]), .hp_mask_i(mk[26]),
        .slot_evt_i(ev[28]), .slot_mask_i(mk[28]),
        .bist_start_i(bist), .bist_ie_i(bist_ie),
        .pme_stat_i(pme), .pme_ie_i(pme_ie),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wd),
        .reg_rdata_o(rdata),
        .irq_main_o(irq_main), .irq_cfg_o(irq_cfg),
        .irq_msg_o(irq_msg), .irq_bist_o(irq_bist)
    );

    int checks = 0, fails = 0;
    string cur_req = "R1";
    logic [31:0] m = '0;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m <= '0;
        else begin
            for (int b = 0; b < 32; b++) begin
                if (STICKY[b]) begin
                    if (ev[b] && !mk[b]) m[b] <= 1'b1;
                    else if (wr && addr == A && wd[b]) m[b] <= 1'b0;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        logic [31:0] v;
        v = m;
        v[24] = bist;
        v[27] = pme;
        return (addr == A) ? v : 32'h0;
    endfunction

    always @(negedge clk) begin
        check(cur_req, rdata, exp_rd());
        check("R10", {31'b0, irq_main}, {31'b0, (|m[5:0]) | m[18]});
        check("R9",  {31'b0, irq_cfg},  {31'b0, m[18]});
        check("R8",  {31'b0, irq_msg},  {31'b0, m[25] | m[26] | m[28] | (pme & pme_ie)});
        check("R6",  {31'b0, irq_bist}, {31'b0, bist & bist_ie});
    end

    task automatic cyc();
        @(negedge clk);
        #2;
    endtask

    task automatic idle();
        ev = '0; mk = '0; wr = 0; wd = '0; addr = A;
    endtask

    initial begin
        #3_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        check("R1", rdata, 32'h0);
        rst_n = 1'b1;
        cyc();
        check("R1", rdata, 32'h0);

        // R2: each source on its own
        cur_req = "R2";
        for (int b = 0; b < 32; b++) begin
            if (STICKY[b]) begin
                ev[b] = 1'b1; cyc(); idle(); cyc();
                check("R2", rdata & (32'h1 << b), 32'h1 << b);
            end
        end
        check("R2", rdata, STICKY);

        // R3: clear with mixed pattern, wrong address, write of zeros
        cur_req = "R3";
        addr = 8'h7C; wr = 1; wd = '1; cyc(); idle(); cyc();
        check("R3", rdata, STICKY);
        wr = 1; wd = '0; cyc(); idle(); cyc();
        check("R3", rdata, STICKY);
        wr = 1; wd = 32'h0004_0015; cyc(); idle(); cyc();
        check("R3", rdata, STICKY & ~32'h0004_0015);
        wr = 1; wd = STICKY; cyc(); idle(); cyc();
        check("R10", {31'b0, irq_main}, 32'h0);
        check("R3", rdata, 32'h0);

        // R4: masked events leave flags clear
        cur_req = "R4";
        ev = STICKY; mk = STICKY; cyc(); idle(); cyc();
        check("R4", rdata, 32'h0);
        ev = STICKY; mk = 32'h1000_000A; cyc(); idle(); cyc();
        check("R4", rdata, STICKY & ~32'h1000_000A);

        // R5: set beats clear in the same cycle
        cur_req = "R5";
        ev = 32'h0200_0001; wr = 1; wd = '1; cyc(); idle(); cyc();
        check("R5", rdata, 32'h0200_0001);
        wr = 1; wd = '1; cyc(); idle(); cyc();
        check("R5", rdata, 32'h0);

        // R6/R7: copy bits and their enables
        cur_req = "R7";
        bist = 1; cyc();
        check("R6", rdata, 32'h0100_0000);
        check("R6", {31'b0, irq_bist}, 32'h0);
        bist_ie = 1; cyc();
        check("R6", {31'b0, irq_bist}, 32'h1);
        pme = 1; cyc();
        check("R8", {31'b0, irq_msg}, 32'h0);
        pme_ie = 1; wr = 1; wd = 32'h0900_0000; cyc(); idle(); cyc();
        check("R7", rdata, 32'h0900_0000);
        check("R8", {31'b0, irq_msg}, 32'h1);
        bist = 0; pme = 0; cyc();
        check("R7", rdata, 32'h0);

        // R11: reserved bits stay zero
        cur_req = "R11";
        ev = '1; cyc(); idle(); wr = 1; wd = '1; cyc(); idle(); cyc();
        check("R11", rdata & 32'hE0F8_0000, 32'h0);

        // R12: random mix with address misses
        cur_req = "R12";
        for (int n = 0; n < 3000; n++) begin
            ev   = $urandom() & $urandom() & STICKY;
            mk   = $urandom() & $urandom();
            wr   = ($urandom_range(0, 3) == 0);
            wd   = $urandom();
            addr = ($urandom_range(0, 4) == 0) ? 8'h70 : A;
            if ($urandom_range(0, 15) == 0) bist = ~bist;
            if ($urandom_range(0, 15) == 0) pme = ~pme;
            bist_ie = $urandom_range(0, 1);
            pme_ie  = $urandom_range(0, 1);
            cyc();
        end
        idle(); cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule